// File: doc/BRIEF.md
# Segmented DAC Cell Control Front End

This block turns a binary sample code into the switch controls of a segmented current-steering converter. The top field of the code is expanded into a unary count of equal-weight cells. The bottom field drives binary-weighted cells one bit per cell. The unary cells are not switched on in index order. The first cell used is the middle one, and each further cell alternates to one side and then the other of the cells already on. This spreads graded errors across the array evenly.

The binary field goes through a register stage that matches the decoder stage, so both fields of one sample arrive together. Every cell has its own output register, and so every control changes on the same clock edge. Each cell has a pair of complementary controls: a steer line and a dump line. When a cell changes state, the line that is being asserted goes high on the edge that carries the new sample. The line that is being released drops one cycle later. This means a cell is never left with both switches open.

Top module: `dac_seg_fe`

## Requirements
- R1: While rst_ni is low, every steer output is 0 and every dump output is 1.
- R2: Once a code has been held, the number of unary steer outputs at 1 equals the value of the top MSB_W bits of code_i.
- R3: Unary cells are ranked by their 1-based physical position p. The centre position is c = ceil(N/2) with N = 2^MSB_W - 1. Position c has rank 1. A position p < c has rank 2(c-p), and a position p > c has rank 2(p-c)+1. Cell p (bit p-1 of the unary buses) is steered exactly when its rank is at most the top field.
- R4: Bit j of bin_on_o follows bit j of code_i[LSB_W-1:0], where LSB_W = DATA_W - MSB_W.
- R5: A code sampled at clock edge k shows on the outputs after edge k+1, a latency of two cycles. The unary and binary paths have the same latency.
- R6: For every cell, the steer output and the dump output are never both 0.
- R7: When a cell is turned on, its steer output rises while its dump output stays 1 for one more cycle. When a cell is turned off, its dump output rises while its steer output stays 1 for one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | DATA_W | Binary sample code |
| unary_on_o | output | 2^MSB_W-1 | Steer control per unary cell, bit p-1 is position p |
| unary_dump_o | output | 2^MSB_W-1 | Dump control per unary cell |
| bin_on_o | output | DATA_W-MSB_W | Steer control per binary-weighted cell |
| bin_dump_o | output | DATA_W-MSB_W | Dump control per binary-weighted cell |

## Verification
A new code can change both the unary count and the binary field in the same cycle. The bench applies field carries such as binary 011 to 100 in the low bits together with a one-step change of the top field. It then checks that both groups settle on the same edge, two cycles after the sample. In that same cycle the make-before-break overlap falls on every cell that changes, in both groups. The bench predicts the steer and dump pattern of the overlap cycle from the previous target and the new one, and it compares every cell in the cycle where the overlap is expected.

// File: rtl/dac_seg_fe_pkg.sv
package dac_seg_fe_pkg;

  // turn-on rank of 1-based position pos among n cells, centre first, alternating out
  function automatic int unsigned sym_rank(input int unsigned pos, input int unsigned n);
    int unsigned c;
    c = (n + 1) / 2;
    if (pos == c)     return 1;
    else if (pos < c) return 2 * (c - pos);
    else              return 2 * (pos - c) + 1;
  endfunction

endpackage

// File: rtl/dac_thermo_dec.sv
module dac_thermo_dec #(
  parameter int unsigned MSB_W = 5,
  localparam int unsigned N    = (1 << MSB_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MSB_W-1:0] field_i,
  output logic [N-1:0]     en_o
);
  import dac_seg_fe_pkg::*;

  logic [N-1:0] dec;
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int unsigned RANK = sym_rank(i + 1, N);
    assign dec[i] = (32'(field_i) >= RANK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= dec;
  end

  assign en_o = en_q;

endmodule

// File: rtl/dac_lsb_dly.sv
module dac_lsb_dly #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= '0;
        else         pipe_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dac_cell_drv.sv
module dac_cell_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic on_o,
  output logic dump_o
);
  logic tgt_q;
  logic on_q;
  logic dump_q;

  // asserting side follows new target at once, releasing side lags one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= 1'b0;
      on_q   <= 1'b0;
      dump_q <= 1'b1;
    end else begin
      tgt_q  <= en_i;
      on_q   <= en_i | tgt_q;
      dump_q <= ~en_i | ~tgt_q;
    end
  end

  assign on_o   = on_q;
  assign dump_o = dump_q;

endmodule

// File: rtl/dac_seg_fe.sv
module dac_seg_fe #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MSB_W  = 5,
  localparam int unsigned LSB_W = DATA_W - MSB_W,
  localparam int unsigned N_UN  = (1 << MSB_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] code_i,
  output logic [N_UN-1:0]   unary_on_o,
  output logic [N_UN-1:0]   unary_dump_o,
  output logic [LSB_W-1:0]  bin_on_o,
  output logic [LSB_W-1:0]  bin_dump_o
);
  localparam int unsigned DEC_LAT = 1;

  logic [N_UN-1:0]  un_en;
  logic [LSB_W-1:0] bin_en;

  dac_thermo_dec #(.MSB_W(MSB_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .field_i (code_i[DATA_W-1 -: MSB_W]),
    .en_o    (un_en)
  );

  dac_lsb_dly #(.W(LSB_W), .STAGES(DEC_LAT)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (code_i[LSB_W-1:0]),
    .q_o    (bin_en)
  );

  for (genvar i = 0; i < N_UN; i++) begin : g_un
    dac_cell_drv u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (un_en[i]),
      .on_o   (unary_on_o[i]),
      .dump_o (unary_dump_o[i])
    );
  end

  for (genvar j = 0; j < LSB_W; j++) begin : g_bin
    dac_cell_drv u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (bin_en[j]),
      .on_o   (bin_on_o[j]),
      .dump_o (bin_dump_o[j])
    );
  end

endmodule

// File: rtl/dac_seg_fe_chk.sv
module dac_seg_fe_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MSB_W  = 5,
  localparam int unsigned LSB_W = DATA_W - MSB_W,
  localparam int unsigned N_UN  = (1 << MSB_W) - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] code_i,
  input logic [N_UN-1:0]   unary_on_o,
  input logic [N_UN-1:0]   unary_dump_o,
  input logic [LSB_W-1:0]  bin_on_o,
  input logic [LSB_W-1:0]  bin_dump_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_off_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (unary_on_o == '0 && unary_dump_o == '1 && bin_on_o == '0 && bin_dump_o == '1));

  assert_unary_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(code_i, 2) == $past(code_i, 3))
    |-> ($countones(unary_on_o) == int'($past(code_i[DATA_W-1 -: MSB_W], 2))
         && unary_dump_o == ~unary_on_o));

  assert_bin_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(code_i, 2) == $past(code_i, 3))
    |-> (bin_on_o == $past(code_i[LSB_W-1:0], 2) && bin_dump_o == ~bin_on_o));

  assert_never_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&(unary_on_o | unary_dump_o)) && (&(bin_on_o | bin_dump_o)));

  assert_make_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0)
    |-> ((unary_on_o & ~$past(unary_on_o) & ~unary_dump_o) == '0
         && (bin_on_o & ~$past(bin_on_o) & ~bin_dump_o) == '0));

  assert_break_late_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0)
    |-> (($past(unary_on_o) & ~unary_on_o & ~$past(unary_dump_o)) == '0
         && ($past(bin_on_o) & ~bin_on_o & ~$past(bin_dump_o)) == '0));

endmodule

bind dac_seg_fe dac_seg_fe_chk #(.DATA_W(DATA_W), .MSB_W(MSB_W)) u_chk (.*);

// File: tb/dac_seg_fe_tb.sv
module dac_seg_fe_tb;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MSB_W  = 5;
  localparam int unsigned LSB_W  = DATA_W - MSB_W;
  localparam int unsigned N_UN   = (1 << MSB_W) - 1;

  typedef struct {
    int unsigned          due;
    logic [MSB_W-1:0]     msb;
    logic [LSB_W-1:0]     lsb;
  } item_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic [DATA_W-1:0] code_i = '0;
  logic [N_UN-1:0]   unary_on_o, unary_dump_o;
  logic [LSB_W-1:0]  bin_on_o, bin_dump_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 0;
  item_t       q[$];

  logic [N_UN-1:0]  prev_un = '0;
  logic [LSB_W-1:0] prev_bin = '0;
  logic [MSB_W-1:0] prev_msb = '0;

  always #2 clk_i = ~clk_i;

  dac_seg_fe #(.DATA_W(DATA_W), .MSB_W(MSB_W)) u_dut (.*);

  // independent model: walk the turn-on sequence centre, left, right, ...
  function automatic logic [N_UN-1:0] model_un(input logic [MSB_W-1:0] m);
    logic [N_UN-1:0] v;
    int c;
    int pos;
    v = '0;
    c = (N_UN + 1) / 2;
    for (int k = 1; k <= int'(m); k++) begin
      if (k == 1)          pos = c;
      else if (k % 2 == 0) pos = c - k / 2;
      else                 pos = c + (k - 1) / 2;
      v[pos-1] = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [DATA_W-1:0] c);
    @(negedge clk_i);
    code_i = c;
    q.push_back('{due: cyc + 2, msb: c[DATA_W-1 -: MSB_W], lsb: c[LSB_W-1:0]});
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    logic [N_UN-1:0] t_un;
    forever begin
      @(posedge clk_i);
      cyc++;
      #1;
      if (rst_ni) begin
        chk((&(unary_on_o | unary_dump_o)) && (&(bin_on_o | bin_dump_o)), "R6 open cell",
            {unary_on_o, bin_on_o}, {unary_dump_o, bin_dump_o});
      end
      while (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front();
        t_un = model_un(it.msb);
        chk(unary_on_o == (t_un | prev_un), "R3/R5 unary steer", 64'(unary_on_o), 64'(t_un | prev_un));
        chk(unary_dump_o == (~t_un | ~prev_un), "R7 unary dump", 64'(unary_dump_o), 64'(~t_un | ~prev_un));
        chk(bin_on_o == (it.lsb | prev_bin), "R4/R5 binary steer", 64'(bin_on_o), 64'(it.lsb | prev_bin));
        chk(bin_dump_o == (~it.lsb | ~prev_bin), "R7 binary dump", 64'(bin_dump_o), 64'(~it.lsb | ~prev_bin));
        if (it.msb == prev_msb)
          chk($countones(unary_on_o) == int'(it.msb), "R2 unary count",
              64'($countones(unary_on_o)), 64'(it.msb));
        prev_un  = t_un;
        prev_bin = it.lsb;
        prev_msb = it.msb;
      end
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(unary_on_o == '0 && bin_on_o == '0, "R1 reset steer", {unary_on_o, bin_on_o}, 64'd0);
    chk(unary_dump_o == '1 && bin_dump_o == '1, "R1 reset dump",
        {unary_dump_o, bin_dump_o}, {{N_UN{1'b1}}, {LSB_W{1'b1}}});
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3: one unary cell only -> centre position 16 -> bit 15
    drive(8'h08); drive(8'h08); drive(8'h08);
    #3;
    chk(unary_on_o == 31'h0000_8000 && unary_dump_o == ~31'h0000_8000, "R3 centre first",
        64'(unary_on_o), 64'h8000);
    // full scale and back to zero
    drive(8'hFF); drive(8'hFF); drive(8'h00); drive(8'h00);
    // R5: binary carry 011->100 together with a one-step unary change
    drive(8'h7B); drive(8'h7B); drive(8'h84); drive(8'h84);
    drive(8'h03); drive(8'h04); drive(8'h04);
    // ramp with holds
    for (int v = 0; v < 256; v++) begin
      drive(8'(v)); drive(8'(v));
    end
    // pseudo-random codes
    for (int k = 0; k < 400; k++) drive(8'($urandom_range(0, 255)));
    drive(8'h55); drive(8'h55); drive(8'h55);
    repeat (4) @(posedge clk_i);
    #1;
    chk(q.size() == 0, "R5 queue drained", 64'(q.size()), 64'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule